// File: doc/BRIEF.md
# Snooped Write-Back Buffer

This block holds dirty cache lines on their way to memory. It sits between a cache and a snooping bus interface. A line comes in with its address and data, either because the cache evicted it or because a snoop forced it out. The entry then waits in a small queue, so that a requester on the bus can be served before the slower memory write is done. The oldest entry is always offered to memory on a request/grant pair, and one entry leaves for each grant.

Every snooped bus address is also compared against every valid entry. On a match the buffer returns that entry's data in the same cycle. A plain bus read leaves the entry in place, so it is still written to memory later. A read-with-intent-to-modify removes a queued entry, because the requester now owns the line and the memory write is no longer needed. The entry at the head of the queue is the exception: it is already offered to memory, so it is never removed this way. An incoming line whose address is already buffered replaces the stored data and keeps its place in the queue.

Top module: `wbuf_snoop`

## Requirements
- R1: After reset the buffer is empty: `mem_req` is 0, `ins_ready` is 1, and `snp_hit` is 0.
- R2: `mem_req` is 1 exactly when at least one entry is held. `mem_addr` and `mem_data` then show the oldest entry, and entries reach memory in the order they were accepted.
- R3: Each clock edge at which `mem_req` and `mem_gnt` are both 1 removes exactly one entry, the oldest.
- R4: `ins_ready` is 0 exactly when all DEPTH entries are held. An insert presented while `ins_ready` is 0 has no effect.
- R5: `snp_hit` is 1 in the same cycle exactly when `snp_valid` is 1 and `snp_addr` equals the address of a held entry. `snp_data` then carries that entry's data.
- R6: A snoop with `snp_rwitm`=0 (bus read) that hits keeps the entry, and the entry is still written to memory later.
- R7: A snoop with `snp_rwitm`=1 (read with intent to modify) that hits an entry other than the oldest removes that entry, so it never reaches memory. The order of the other entries does not change.
- R8: A snoop with `snp_rwitm`=1 that hits the oldest entry does not remove it. The data is still supplied and the entry still goes to memory.
- R9: An accepted insert whose address matches an entry that stays held this cycle overwrites that entry's data. It keeps the entry's position and does not use a new entry.
- R10: `mem_gnt` while `mem_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | A dirty line is offered for buffering |
| ins_addr | input | AW | Line address of the offered line |
| ins_data | input | DW | Line data of the offered line |
| ins_ready | output | 1 | Buffer can accept a line this cycle |
| mem_req | output | 1 | Oldest entry is offered to memory |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |
| mem_gnt | input | 1 | Memory takes the offered entry |
| snp_valid | input | 1 | A snooped bus address is present |
| snp_rwitm | input | 1 | 1: read with intent to modify, 0: bus read |
| snp_addr | input | AW | Snooped line address |
| snp_hit | output | 1 | Snooped address is held in the buffer |
| snp_data | output | DW | Data of the matching entry |

## Verification
A wrong fill count shows on `ins_ready` in the next cycle, and a queue that lost, duplicated or reordered an entry shows on `mem_addr` at the next grant. A faulty compaction after a cancel is visible only when the shifted entries reach the head, so the bench drains the queue after each directed case and compares the full order. A stale or wrong data slot after a merge appears at once on `snp_data` when the same address is snooped. A drain, on the other hand, exposes it only when that entry is granted.

// File: rtl/wbb_pkg.sv
`timescale 1ns/1ps
package wbb_pkg;
  // Fill level after one cycle: pops and cancels leave, a fresh allocation enters.
  function automatic int unsigned next_fill(input int unsigned cur, input bit popped,
                                            input int unsigned dropped, input bit added);
    int unsigned r;
    r = cur - (popped ? 1 : 0) - dropped + (added ? 1 : 0);
    return r;
  endfunction

  // Room for a new line while fill is below depth.
  function automatic bit has_room(input int unsigned fill, input int unsigned depth);
    return fill < depth;
  endfunction
endpackage

// File: rtl/wbb_match.sv
`timescale 1ns/1ps
module wbb_match #(
  parameter int N  = 4,
  parameter int AW = 26
) (
  input  logic            en,
  input  logic [AW-1:0]   key,
  input  logic [N-1:0]    vld,
  input  logic [N*AW-1:0] addr_flat,
  output logic [N-1:0]    hit_vec,
  output logic            any_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = en && vld[g] && (addr_flat[g*AW +: AW] == key);
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/wbb_queue.sv
`timescale 1ns/1ps
module wbb_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 26,
  parameter int DW    = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pop,
  input  logic [DEPTH-1:0]   drop,
  input  logic               ins_en,
  input  logic [DEPTH-1:0]   ins_hit,
  input  logic [AW-1:0]      ins_addr,
  input  logic [DW-1:0]      ins_data,
  output logic [DEPTH-1:0]   vld,
  output logic [DEPTH*AW-1:0] addr_flat,
  output logic [DEPTH*DW-1:0] data_flat,
  output logic [CW-1:0]      fill,
  output logic               merge_ev
);
  import wbb_pkg::*;

  logic [AW-1:0]    a_q [DEPTH];
  logic [DW-1:0]    d_q [DEPTH];
  logic [AW-1:0]    a_n [DEPTH];
  logic [DW-1:0]    d_n [DEPTH];
  logic [DEPTH-1:0] v_q, v_n, keep, merge_vec;
  logic [CW-1:0]    fill_q, fill_n, slot;
  logic             alloc_ev;

  assign keep      = v_q & ~drop & ~{{(DEPTH-1){1'b0}}, pop};
  assign merge_vec = ins_hit & keep;
  assign merge_ev  = ins_en && (|merge_vec);
  assign alloc_ev  = ins_en && !merge_ev;

  // Compact surviving entries toward slot 0, then append a fresh line.
  always_comb begin
    slot = '0;
    v_n  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      a_n[i] = '0;
      d_n[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        a_n[slot[IW-1:0]] = a_q[i];
        d_n[slot[IW-1:0]] = (ins_en && merge_vec[i]) ? ins_data : d_q[i];
        v_n[slot[IW-1:0]] = 1'b1;
        slot = slot + CW'(1);
      end
    end
    if (alloc_ev && has_room(int'(slot), DEPTH)) begin
      a_n[slot[IW-1:0]] = ins_addr;
      d_n[slot[IW-1:0]] = ins_data;
      v_n[slot[IW-1:0]] = 1'b1;
    end
  end

  assign fill_n = CW'(next_fill(int'(fill_q), pop && v_q[0],
                                $countones(drop & v_q), alloc_ev));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      v_q    <= v_n;
      fill_q <= fill_n;
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= a_n[i];
        d_q[i] <= d_n[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign addr_flat[g*AW +: AW] = a_q[g];
    assign data_flat[g*DW +: DW] = d_q[g];
  end
  assign vld  = v_q;
  assign fill = fill_q;

  // R2
  fill_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_q) == $countones(v_q));

  // R2
  packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((v_q + {{(DEPTH-1){1'b0}}, 1'b1}) & v_q) == '0);

  // R9
  merge_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_ev && !pop && drop == '0) |=> fill_q == $past(fill_q));
endmodule

// File: rtl/wbuf_snoop.sv
`timescale 1ns/1ps
module wbuf_snoop #(
  parameter int DEPTH = 4,
  parameter int AW    = 26,
  parameter int DW    = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  output logic          ins_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_gnt,
  input  logic          snp_valid,
  input  logic          snp_rwitm,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hit,
  output logic [DW-1:0] snp_data
);
  import wbb_pkg::*;

  logic [DEPTH-1:0]    q_vld, snp_vec, ins_vec, cancel_vec;
  logic [DEPTH*AW-1:0] q_addr;
  logic [DEPTH*DW-1:0] q_data;
  logic [CW-1:0]       fill;
  logic                ins_fire, pop_ev, merge_ev, ins_any;

  assign ins_ready = has_room(int'(fill), DEPTH);
  assign ins_fire  = ins_valid && ins_ready;
  assign mem_req   = q_vld[0];
  assign mem_addr  = q_addr[AW-1:0];
  assign mem_data  = q_data[DW-1:0];
  assign pop_ev    = mem_req && mem_gnt;

  wbb_match #(.N(DEPTH), .AW(AW)) u_snp_cmp (
    .en(snp_valid), .key(snp_addr), .vld(q_vld), .addr_flat(q_addr),
    .hit_vec(snp_vec), .any_hit(snp_hit));

  wbb_match #(.N(DEPTH), .AW(AW)) u_ins_cmp (
    .en(ins_valid), .key(ins_addr), .vld(q_vld), .addr_flat(q_addr),
    .hit_vec(ins_vec), .any_hit(ins_any));

  // The head is offered to memory and is never cancelled.
  assign cancel_vec = snp_rwitm ? (snp_vec & ~{{(DEPTH-1){1'b0}}, 1'b1}) : '0;

  always_comb begin
    snp_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (snp_vec[i]) snp_data = snp_data | q_data[i*DW +: DW];
  end

  wbb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_q (
    .clk(clk), .rst_n(rst_n), .pop(pop_ev), .drop(cancel_vec),
    .ins_en(ins_fire), .ins_hit(ins_vec), .ins_addr(ins_addr), .ins_data(ins_data),
    .vld(q_vld), .addr_flat(q_addr), .data_flat(q_data), .fill(fill),
    .merge_ev(merge_ev));

  // R5
  snoop_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snp_vec));

  // R9
  ins_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_vec) && (ins_any || !merge_ev));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // R3
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !ins_fire && cancel_vec == '0) |=> fill == $past(fill) - CW'(1));

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && snp_rwitm && snp_vec[0]) |=>
      (mem_req && mem_addr == $past(mem_addr)));

  // R10
  idle_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && mem_gnt && !ins_fire) |=> !mem_req);
endmodule

// File: tb/sim_wbuf_snoop.sv
`timescale 1ns/1ps
module sim_wbuf_snoop;
  localparam int DEPTH = 4;
  localparam int AW    = 26;
  localparam int DW    = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ins_valid, ins_ready, mem_req, mem_gnt, snp_valid, snp_rwitm, snp_hit;
  logic [AW-1:0] ins_addr, mem_addr, snp_addr;
  logic [DW-1:0] ins_data, mem_data, snp_data;

  int vectors = 0;
  int fails   = 0;

  logic [AW-1:0] m_a [DEPTH];
  logic [DW-1:0] m_d [DEPTH];
  int            m_n = 0;

  always #2 clk = ~clk;

  wbuf_snoop #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_data(ins_data), .ins_ready(ins_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_gnt(mem_gnt),
    .snp_valid(snp_valid), .snp_rwitm(snp_rwitm), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_data(snp_data));

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a, input int salt);
    return {32'(a) ^ 32'hC0DE_0000, 32'(salt) * 32'h0001_0003};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ins_valid = 1'b0; ins_addr = '0; ins_data = '0; mem_gnt = 1'b0;
    snp_valid = 1'b0; snp_rwitm = 1'b0; snp_addr = '0;
  endtask

  // One cycle: drive, compare combinational outputs to the model, advance model.
  task automatic step(input bit iv, input logic [AW-1:0] ia, input logic [DW-1:0] idat,
                      input bit gnt, input bit sv, input bit srw, input logic [AW-1:0] sa);
    logic [AW-1:0] na [DEPTH];
    logic [DW-1:0] nd [DEPTH];
    int  nn, hit_i;
    bit  acc, merged;
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; ins_data = idat; mem_gnt = gnt;
    snp_valid = sv; snp_rwitm = srw; snp_addr = sa;
    #1;
    chk("R4 ready", DW'(ins_ready), DW'(m_n < DEPTH));
    chk("R2 req", DW'(mem_req), DW'(m_n > 0));
    if (m_n > 0) begin
      chk("R2 head addr", DW'(mem_addr), DW'(m_a[0]));
      chk("R2 head data", mem_data, m_d[0]);
    end
    hit_i = -1;
    for (int i = 0; i < m_n; i++) if (sv && m_a[i] == sa) hit_i = i;
    chk("R5 hit", DW'(snp_hit), DW'(hit_i >= 0));
    if (hit_i >= 0) chk("R5 data", snp_data, m_d[hit_i]);
    acc = iv && (m_n < DEPTH);
    nn = 0;
    for (int i = 0; i < DEPTH; i++) begin na[i] = '0; nd[i] = '0; end
    for (int i = 0; i < m_n; i++) begin
      if (i == 0 && gnt) continue;              // R3
      if (i != 0 && sv && srw && m_a[i] == sa) continue;  // R7
      na[nn] = m_a[i]; nd[nn] = m_d[i]; nn++;
    end
    merged = 1'b0;
    if (acc) for (int i = 0; i < nn; i++) if (na[i] == ia) begin nd[i] = idat; merged = 1'b1; end
    if (acc && !merged) begin na[nn] = ia; nd[nn] = idat; nn++; end
    for (int i = 0; i < DEPTH; i++) begin m_a[i] = na[i]; m_d[i] = nd[i]; end
    m_n = nn;
    @(posedge clk);
    #1;
    idle_inputs();
    #0.5;
  endtask

  localparam logic [AW-1:0] A0 = 26'h100, A1 = 26'h101, A2 = 26'h102, A3 = 26'h103;

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 req", DW'(mem_req), 64'd0);
    chk("R1 ready", DW'(ins_ready), 64'd1);
    snp_valid = 1'b1; snp_addr = A0; #0.5;
    chk("R1 hit", DW'(snp_hit), 64'd0);
    idle_inputs();

    // Fill to depth; R4 full stalls
    step(1, A0, line_of(A0, 1), 0, 0, 0, '0);
    step(1, A1, line_of(A1, 1), 0, 0, 0, '0);
    step(1, A2, line_of(A2, 1), 0, 0, 0, '0);
    step(1, A3, line_of(A3, 1), 0, 0, 0, '0);
    chk("R4 full", DW'(ins_ready), 64'd0);
    step(1, 26'h1FF, line_of(26'h1FF, 9), 0, 0, 0, '0);
    chk("R4 ignored", DW'(ins_ready), 64'd0);

    // R6 bus read hit keeps entry
    step(0, '0, '0, 0, 1, 0, A2);
    chk("R6 kept", DW'(ins_ready), 64'd0);
    // R8 rwitm on head keeps it
    step(0, '0, '0, 0, 1, 1, A0);
    chk("R8 head", DW'(mem_addr), DW'(A0));
    chk("R8 kept", DW'(ins_ready), 64'd0);
    // R7 rwitm on non-head cancels
    step(0, '0, '0, 0, 1, 1, A1);
    chk("R7 freed", DW'(ins_ready), 64'd1);
    chk("R7 head", DW'(mem_addr), DW'(A0));
    // R9 merge into A3
    step(1, A3, line_of(A3, 7), 0, 0, 0, '0);
    chk("R9 no alloc", DW'(ins_ready), 64'd1);
    step(0, '0, '0, 0, 1, 0, A3);

    // Drain: expected order A0, A2, A3(new data)
    chk("R7 order0", DW'(mem_addr), DW'(A0));
    step(0, '0, '0, 1, 0, 0, '0);
    chk("R7 order1", DW'(mem_addr), DW'(A2));
    chk("R6 drained", mem_data, line_of(A2, 1));
    step(0, '0, '0, 1, 0, 0, '0);
    chk("R9 order2", DW'(mem_addr), DW'(A3));
    chk("R9 data", mem_data, line_of(A3, 7));
    step(0, '0, '0, 1, 0, 0, '0);
    chk("R3 empty", DW'(mem_req), 64'd0);
    // R10 grant while empty
    step(0, '0, '0, 1, 0, 0, '0);
    chk("R10 req", DW'(mem_req), 64'd0);
    chk("R10 ready", DW'(ins_ready), 64'd1);

    // Random mix over a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] ra, rs;
      ra = 26'h200 + AW'($urandom % 6);
      rs = 26'h200 + AW'($urandom % 6);
      step(($urandom % 2) == 0, ra, {$urandom, $urandom}, ($urandom % 5) < 2,
           ($urandom % 5) < 2, ($urandom % 2) == 0, rs);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule